// File: doc/BRIEF.md
# SPI Master Controller with Register Interface

This block is a single-lane SPI master driven through six 32-bit word registers. Software picks one of eight slave-select lines by index, enables it, sets the clock mode and the serial clock rate, and then writes a byte to the transmit register. That write starts one 8-bit full-duplex exchange, sent most significant bit first. When the exchange ends, the received byte is held in the receive register, a ready bit is set in the control register, and an interrupt status bit is raised.

The serial clock rate is the core clock divided by a linear factor of 2 to 15 times a power of two from 1 to 128. The three exponent bits are stored in two separate fields of the configuration word. The interrupt output is the status bit gated by a mask bit. Reads are combinational from the word address. Writes take effect on the clock edge on which the request is sampled.

Top module: `spi_ctl`

## Requirements
- R1: Registers are decoded from `bus_addr_i[4:2]` and only when `bus_addr_i[1:0]` is zero: 0 control, 1 configuration, 2 transmit, 3 receive, 4 status, 5 mask. Other addresses read zero. After reset, every register reads zero.
- R2: Control bit 0 enables selection and bits 4:2 give the index. While bit 0 is set, only `cs_no[index]` is low. While it is clear, all eight lines are high.
- R3: A write to the transmit register while idle starts an exchange. `mosi_o` sends bits 7:0 of the written byte, MSB first. The 8 bits sampled from `miso_i` are placed in bits 7:0 of the receive register when the exchange ends. The transmit register reads back the last byte that started an exchange.
- R4: Configuration bits 13:12 hold the mode. Bit 13 is CPOL and bit 12 is CPHA. While idle, `sclk_o` rests at CPOL. With CPHA clear, data is sampled on the first clock edge of each bit. With CPHA set, data is sampled on the second edge.
- R5: The divider is D = S × 2^P. S is configuration bits 3:0, and values 0 and 1 act as 2. P has its bit 0 at configuration bit 4 and its bits 2:1 at configuration bits 7:6. One exchange lasts exactly 8·D core cycles, counted from the write edge to the edge that sets ready.
- R6: Control bit 1 is read-only. It is set on the edge that ends an exchange and cleared by a write to the transmit register that starts one.
- R7: A transmit write during an exchange is ignored. The current exchange and the stored transmit byte are unchanged. The receive register changes only on the edge that ends an exchange.
- R8: Status bit 0 is set when an exchange ends. Writing the status register with bit 0 at zero clears it, and writing a 1 has no effect. `irq_o` is high exactly when status bit 0 and mask bit 0 are both set.
- R9: Configuration bit 5 (two-byte length) is stored and read back. The exchange is still 8 bits and 8·D cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 5 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_no | output | 8 | Slave selects, active low |
| irq_o | output | 1 | Ready interrupt |

## Verification
If the bit counter or the divider state is wrong, the exchange length at the ports is wrong. The bench measures that length to the exact cycle for five divider settings, so this kind of fault shows up within one exchange. If the shift registers are wrong, the slave model captures the wrong byte on its eighth sampling edge, or the wrong value appears in the receive register as soon as ready rises. A wrong busy or status state shows up one cycle after the offending write: the ready bit, the interrupt line, or the transmit readback is wrong.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int unsigned BUS_AW = 5;
  localparam int unsigned BUS_DW = 32;

  typedef enum logic [2:0] {
    SEL_CTRL = 3'd0,
    SEL_CFG  = 3'd1,
    SEL_TX   = 3'd2,
    SEL_RX   = 3'd3,
    SEL_STAT = 3'd4,
    SEL_MASK = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/spi_ctl_clkdiv.sv
module spi_ctl_clkdiv #(
  parameter int unsigned SPR_W  = 4,
  parameter int unsigned SPPR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [SPR_W-1:0]  spr_i,
  input  logic [SPPR_W-1:0] sppr_i,
  output logic              lead_o,
  output logic              trail_o
);
  localparam int unsigned DIV_W = SPR_W + (1 << SPPR_W) - 1;

  logic [SPR_W-1:0] spr_eff;
  logic [DIV_W-1:0] div, half, cnt_q;

  assign spr_eff = (spr_i < SPR_W'(2)) ? SPR_W'(2) : spr_i;
  assign div     = {{(DIV_W-SPR_W){1'b0}}, spr_eff} << sppr_i;
  assign half    = div >> 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!run_i)                 cnt_q <= '0;
    else if (cnt_q == div - DIV_W'(1)) cnt_q <= '0;
    else                             cnt_q <= cnt_q + DIV_W'(1);
  end

  // first edge closes the low half, second edge closes the bit
  assign lead_o  = run_i && (cnt_q == half - DIV_W'(1));
  assign trail_o = run_i && (cnt_q == div - DIV_W'(1));
endmodule

// File: rtl/spi_ctl_shift.sv
module spi_ctl_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              cpha_i,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o,
  output logic              mosi_o,
  output logic              sclk_ph_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);

  logic              busy_q, out_q, ph_q, last;
  logic [CNT_W-1:0]  bit_q;
  logic [DATA_W-1:0] tx_sh, rx_sh, rx_q, rx_word;

  assign last    = bit_q == CNT_W'(DATA_W-1);
  assign done_o  = busy_q && trail_i && last;
  assign rx_word = cpha_i ? {rx_sh[DATA_W-2:0], miso_i} : rx_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      out_q  <= 1'b0;
      ph_q   <= 1'b0;
      bit_q  <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      rx_q   <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      ph_q   <= 1'b0;
      bit_q  <= '0;
      if (cpha_i) begin
        tx_sh <= tx_i;
      end else begin
        out_q <= tx_i[DATA_W-1];
        tx_sh <= tx_i << 1;
      end
    end else if (busy_q) begin
      if (lead_i) begin
        ph_q <= 1'b1;
        if (cpha_i) begin
          out_q <= tx_sh[DATA_W-1];
          tx_sh <= tx_sh << 1;
        end else begin
          rx_sh <= {rx_sh[DATA_W-2:0], miso_i};
        end
      end
      if (trail_i) begin
        ph_q  <= 1'b0;
        bit_q <= bit_q + CNT_W'(1);
        if (cpha_i) begin
          rx_sh <= {rx_sh[DATA_W-2:0], miso_i};
        end else if (!last) begin
          out_q <= tx_sh[DATA_W-1];
          tx_sh <= tx_sh << 1;
        end
        if (last) begin
          busy_q <= 1'b0;
          rx_q   <= rx_word;
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign rx_o      = rx_q;
  assign mosi_o    = out_q;
  assign sclk_ph_o = ph_q;
endmodule

// File: rtl/spi_ctl_regs.sv
module spi_ctl_regs
  import spi_ctl_pkg::*;
#(
  parameter int unsigned CS_W   = 3,
  parameter int unsigned SPR_W  = 4,
  parameter int unsigned SPPR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output logic              start_o,
  output logic [DATA_W-1:0] tx_o,
  output logic              cs_en_o,
  output logic [CS_W-1:0]   cs_idx_o,
  output logic [SPR_W-1:0]  spr_o,
  output logic [SPPR_W-1:0] sppr_o,
  output logic              cpol_o,
  output logic              cpha_o,
  output logic              ready_o,
  output logic              mask_o,
  output logic              irq_o
);
  logic              hit, wr;
  reg_sel_e          sel;
  logic              en_q, ready_q, wide_q, stat_q, mask_q;
  logic [CS_W-1:0]   idx_q;
  logic [SPR_W-1:0]  spr_q;
  logic [SPPR_W-1:0] sppr_q;
  logic [1:0]        mode_q;
  logic [DATA_W-1:0] tx_q;
  logic              unused_wdata;

  assign hit = bus_addr_i[1:0] == 2'b00;
  assign sel = reg_sel_e'(bus_addr_i[4:2]);
  assign wr  = bus_req_i && bus_we_i && hit;
  assign start_o = wr && (sel == SEL_TX) && !busy_i;
  assign unused_wdata = ^{bus_wdata_i[BUS_DW-1:14], bus_wdata_i[11:8]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      idx_q   <= '0;
      ready_q <= 1'b0;
      spr_q   <= '0;
      sppr_q  <= '0;
      wide_q  <= 1'b0;
      mode_q  <= '0;
      tx_q    <= '0;
      stat_q  <= 1'b0;
      mask_q  <= 1'b0;
    end else begin
      if (wr && sel == SEL_CTRL) begin
        en_q  <= bus_wdata_i[0];
        idx_q <= bus_wdata_i[2 +: CS_W];
      end
      if (wr && sel == SEL_CFG) begin
        spr_q  <= bus_wdata_i[SPR_W-1:0];
        sppr_q <= {bus_wdata_i[7:6], bus_wdata_i[4]};
        wide_q <= bus_wdata_i[5];
        mode_q <= bus_wdata_i[13:12];
      end
      if (start_o) tx_q <= bus_wdata_i[DATA_W-1:0];
      if (wr && sel == SEL_MASK) mask_q <= bus_wdata_i[0];

      if (done_i)       ready_q <= 1'b1;
      else if (start_o) ready_q <= 1'b0;

      // completion wins over a same-cycle clear
      if (done_i)                                       stat_q <= 1'b1;
      else if (wr && sel == SEL_STAT && !bus_wdata_i[0]) stat_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (hit) begin
      case (sel)
        SEL_CTRL: bus_rdata_o[2+CS_W-1:0] = {idx_q, ready_q, en_q};
        SEL_CFG: begin
          bus_rdata_o[SPR_W-1:0] = spr_q;
          bus_rdata_o[4]         = sppr_q[0];
          bus_rdata_o[5]         = wide_q;
          bus_rdata_o[7:6]       = sppr_q[2:1];
          bus_rdata_o[13:12]     = mode_q;
        end
        SEL_TX:   bus_rdata_o[DATA_W-1:0] = tx_q;
        SEL_RX:   bus_rdata_o[DATA_W-1:0] = rx_i;
        SEL_STAT: bus_rdata_o[0] = stat_q;
        SEL_MASK: bus_rdata_o[0] = mask_q;
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  assign tx_o     = tx_q;
  assign cs_en_o  = en_q;
  assign cs_idx_o = idx_q;
  assign spr_o    = spr_q;
  assign sppr_o   = sppr_q;
  assign cpol_o   = mode_q[1];
  assign cpha_o   = mode_q[0];
  assign ready_o  = ready_q;
  assign mask_o   = mask_q;
  assign irq_o    = stat_q & mask_q;
endmodule

// File: rtl/spi_ctl.sv
module spi_ctl
  import spi_ctl_pkg::*;
#(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SPR_W  = 4,
  parameter int unsigned SPPR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [BUS_AW-1:0] bus_addr_i,
  input  logic [BUS_DW-1:0] bus_wdata_i,
  output logic [BUS_DW-1:0] bus_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_no,
  output logic              irq_o
);
  localparam int unsigned CS_W = $clog2(NUM_CS);

  logic              start_w, busy_w, done_w, cs_en_w, cpol_w, cpha_w;
  logic              lead_w, trail_w, ph_w, ready_w, mask_w;
  logic [DATA_W-1:0] tx_w, rx_w;
  logic [CS_W-1:0]   cs_idx_w;
  logic [SPR_W-1:0]  spr_w;
  logic [SPPR_W-1:0] sppr_w;

  spi_ctl_regs #(
    .CS_W(CS_W), .SPR_W(SPR_W), .SPPR_W(SPPR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .bus_req_i(bus_req_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .busy_i(busy_w), .done_i(done_w), .rx_i(rx_w),
    .start_o(start_w), .tx_o(tx_w), .cs_en_o(cs_en_w), .cs_idx_o(cs_idx_w),
    .spr_o(spr_w), .sppr_o(sppr_w), .cpol_o(cpol_w), .cpha_o(cpha_w),
    .ready_o(ready_w), .mask_o(mask_w), .irq_o(irq_o)
  );

  spi_ctl_clkdiv #(.SPR_W(SPR_W), .SPPR_W(SPPR_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_w),
    .spr_i(spr_w), .sppr_i(sppr_w), .lead_o(lead_w), .trail_o(trail_w)
  );

  spi_ctl_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_w),
    .tx_i(bus_wdata_i[DATA_W-1:0]), .cpha_i(cpha_w),
    .lead_i(lead_w), .trail_i(trail_w), .miso_i(miso_i),
    .busy_o(busy_w), .done_o(done_w), .rx_o(rx_w),
    .mosi_o(mosi_o), .sclk_ph_o(ph_w)
  );

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_no[g] = !(cs_en_w && (cs_idx_w == CS_W'(g)));
  end

  assign sclk_o = cpol_w ^ ph_w;

  logic unused_tx;
  assign unused_tx = ^tx_w;
endmodule

// File: rtl/spi_ctl_chk.sv
module spi_ctl_chk #(
  parameter int unsigned NUM_CS = 8,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [4:0]        bus_addr_i,
  input logic [NUM_CS-1:0] cs_no,
  input logic              cs_en_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              ready_i,
  input logic [DATA_W-1:0] rx_i,
  input logic              sclk_i,
  input logic              cpol_i,
  input logic              mask_i,
  input logic              irq_i
);
  logic tx_wr;
  assign tx_wr = bus_req_i && bus_we_i && (bus_addr_i == 5'h08);

  // R2
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no));
  // R2
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_en_i |-> &cs_no);
  // R4
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sclk_i == cpol_i);
  // R6
  ready_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_i) |-> $fell(busy_i));
  // R7
  busy_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && tx_wr && !done_i |=> busy_i);
  // R7
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(rx_i));
  // R8
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> mask_i);
endmodule

bind spi_ctl spi_ctl_chk #(.NUM_CS(NUM_CS), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .cs_no(cs_no), .cs_en_i(cs_en_w), .busy_i(busy_w),
  .done_i(done_w), .ready_i(ready_w), .rx_i(rx_w), .sclk_i(sclk_o),
  .cpol_i(cpol_w), .mask_i(mask_w), .irq_i(irq_o)
);

// File: tb/spi_ctl_bench.sv
`timescale 1ns/1ps
module spi_ctl_bench;
  localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_TX = 5'h08,
                         A_RX = 5'h0C, A_STAT = 5'h10, A_MASK = 5'h14;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        sclk, mosi, irq;
  logic        miso;
  logic [7:0]  cs_n;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_ctl u_spi_ctl (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .cs_no(cs_n), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // slave model and scoreboard monitor
  logic [7:0] exp_q[$];
  bit         s_cpol = 0, s_cpha = 0;
  bit         ld_tog = 0, ld_seen = 0;
  logic [7:0] ld_byte = '0, s_sh = '0, s_cap = '0;
  logic       s_miso = 1'b0, s_prev = 1'b0;
  int         s_cnt = 0;
  assign miso = s_miso;

  always @(negedge clk) begin
    if (ld_tog != ld_seen) begin
      ld_seen = ld_tog;
      s_cnt = 0;
      if (s_cpha) s_sh = ld_byte;
      else begin s_miso = ld_byte[7]; s_sh = ld_byte << 1; end
    end else if (s_prev == s_cpol && sclk != s_cpol) begin
      if (s_cpha) begin s_miso = s_sh[7]; s_sh = s_sh << 1; end
      else begin s_cap = {s_cap[6:0], mosi}; s_cnt++; end
    end else if (s_prev != s_cpol && sclk == s_cpol) begin
      if (s_cpha) begin s_cap = {s_cap[6:0], mosi}; s_cnt++; end
      else begin s_miso = s_sh[7]; s_sh = s_sh << 1; end
    end
    s_prev = sclk;
    if (s_cnt == 8) begin
      s_cnt = 0;
      if (exp_q.size() == 0) chk(0, "R3 mosi byte with no exchange queued", s_cap, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(s_cap == e, "R3 mosi byte", s_cap, e);
      end
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] cfg(input int mode, input int spr, input int sppr, input bit wide);
    return (32'(mode) << 12) | (32'((sppr >> 1) & 3) << 6) | (32'(wide) << 5)
         | (32'(sppr & 1) << 4) | 32'(spr & 15);
  endfunction

  task automatic set_cfg(input int mode, input int spr, input int sppr, input bit wide);
    wr(A_CFG, cfg(mode, spr, sppr, wide));
    s_cpol = mode[1];
    s_cpha = mode[0];
    @(negedge clk);
    chk(sclk == s_cpol, "R4 idle sclk level", sclk, s_cpol);
  endtask

  // driver: push expected byte, start, time the exchange, check rx
  task automatic xfer(input logic [7:0] tx, input logic [7:0] slv, input int d, input bit poke);
    logic [31:0] r;
    int n;
    ld_byte = slv;
    ld_tog = ~ld_tog;
    exp_q.push_back(tx);
    wr(A_TX, {24'h0, tx});
    n = 0;
    r = '0;
    while (n < 20000) begin
      @(negedge clk);
      n++;
      req = 0; we = 0;
      if (poke && n == 3) begin
        req = 1; we = 1; addr = A_TX; wdata = {24'h0, ~tx};
      end else begin
        addr = A_CTRL;
        #1 r = rdata;
        if (r[1]) break;
      end
    end
    req = 0; we = 0;
    chk(n == 8 * d, "R5 exchange length in cycles", n, 8 * d);
    rd(A_RX, r);
    chk(r == {24'h0, slv}, "R3 received byte", r, slv);
    rd(A_TX, r);
    chk(r[7:0] == tx, "R7 transmit readback", r, tx);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int i = 0; i < 8; i++) begin
      rd(5'(i * 4), r);
      chk(r == 0, "R1 reset value", r, 0);
    end
    chk(cs_n == 8'hFF, "R2 reset selects", cs_n, 8'hFF);
    chk(irq == 0, "R8 reset irq", irq, 0);

    wr(A_MASK, 1);
    set_cfg(0, 2, 0, 0);
    wr(A_CTRL, (3 << 2) | 1);
    rd(A_CTRL, r);
    chk(r == 32'h0D, "R1 control readback", r, 32'h0D);
    chk(cs_n == ~8'h08, "R2 select index 3", cs_n, ~8'h08);
    wr(A_CTRL, 32'h0F);   // bit 1 written as 1 must not stick
    rd(A_CTRL, r);
    chk(r[1] == 0, "R6 ready is read-only", r, 0);
    rd(5'h09, r);
    chk(r == 0, "R1 unaligned address reads zero", r, 0);

    xfer(8'hA5, 8'h3C, 2, 0);
    chk(irq == 1, "R8 irq after exchange", irq, 1);
    wr(A_STAT, 1);
    @(negedge clk);
    chk(irq == 1, "R8 writing 1 keeps status", irq, 1);
    wr(A_STAT, 0);
    @(negedge clk);
    chk(irq == 0, "R8 status cleared by zero", irq, 0);

    set_cfg(1, 3, 1, 0);
    xfer(8'h5A, 8'hC3, 6, 0);
    set_cfg(2, 5, 2, 0);
    rd(A_CFG, r);
    chk(r == 32'h2045, "R5 split exponent field readback", r, 32'h2045);
    xfer(8'h81, 8'h7E, 20, 0);
    set_cfg(3, 15, 5, 0);
    xfer(8'h0F, 8'hF0, 480, 0);

    // R5 factor below 2 acts as 2
    set_cfg(0, 0, 0, 0);
    xfer(8'hD2, 8'h4B, 2, 0);
    set_cfg(3, 1, 1, 0);
    xfer(8'h33, 8'h99, 4, 0);

    // R6 ready cleared by start; R7 rx holds until done
    set_cfg(1, 3, 1, 0);
    ld_byte = 8'h11;
    ld_tog = ~ld_tog;
    exp_q.push_back(8'hE7);
    wr(A_TX, 32'hE7);
    rd(A_CTRL, r);
    chk(r[1] == 0, "R6 ready cleared by start", r[1], 0);
    rd(A_RX, r);
    chk(r == 32'h99, "R7 rx holds during exchange", r, 32'h99);
    repeat (60) @(negedge clk);
    rd(A_RX, r);
    chk(r == 32'h11, "R3 rx after exchange", r, 32'h11);

    // R7 write during exchange ignored
    xfer(8'h6C, 8'h2D, 6, 1);

    // R8 mask gates irq
    wr(A_STAT, 0);
    wr(A_MASK, 0);
    xfer(8'h44, 8'h88, 6, 0);
    chk(irq == 0, "R8 masked irq low", irq, 0);
    rd(A_STAT, r);
    chk(r == 1, "R8 status set while masked", r, 1);
    wr(A_MASK, 1);
    @(negedge clk);
    chk(irq == 1, "R8 irq on unmask", irq, 1);

    // R9 two-byte bit stored but exchange stays 8 bits
    set_cfg(0, 2, 1, 1);
    rd(A_CFG, r);
    chk(r[5] == 1, "R9 length bit readback", r[5], 1);
    xfer(8'hB7, 8'h5E, 4, 0);

    // R2 select lines
    wr(A_CTRL, (7 << 2) | 1);
    chk(cs_n == ~8'h80, "R2 select index 7", cs_n, ~8'h80);
    wr(A_CTRL, 7 << 2);
    chk(cs_n == 8'hFF, "R2 disabled selects high", cs_n, 8'hFF);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all queued bytes seen", exp_q.size(), 0);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule